// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit up-counter with four operating modes, configured through a byte-wide register port. It holds two control bytes and two 16-bit data registers, A and B. The counter advances on one of three prescaled taps of the system clock or on edges of a single external input. From that counter the block can run as a periodic timer, a trigger-started timer, an event counter, a gated (window) counter, a pulse-width meter that captures into B, or a programmable pulse generator that drives one output pin.

A and B are double-buffered. A lower-byte write only fills a holding byte. An upper-byte write stages the full 16-bit value, and that value becomes active on the next source tick. Every counting event that a mode defines raises a one-cycle interrupt pulse. The external input passes through two synchroniser flops before any edge or level is taken from it. Register reads are registered, so read data appears one clock after the address is presented.

Top module: `mmt16_timer`

## Requirements
- R1: After reset, both control bytes read 0x00, A and B read 0xFFFF, and pulse_out and irq are low.
- R2: Address map: 0 is control low, with mode in [1:0], start in [3:2] and source in [6:4]. 1 is control high, with initial level [0], auto-capture [1], single-edge [2], trigger-stop [3] and one-shot [4]. 2/3 are A low/high, 4/5 are B low/high, and 6/7 are count low/high (read-only). A lower-byte write alone never changes the active value. After an upper-byte write, the staged value becomes active on the first source tick that follows.
- R3: Writes to B are ignored unless the mode is 11 (pulse generator). In that mode they load through the same staging as A.
- R4: Source 0, 1 and 2 tick every 2^11, 2^7 and 2^3 clocks; source 3 to 7 selects synchronised rising edges of ext_in. In mode 00 with a prescaled source, a command start (start 01) makes the counter step on each tick. When a step would reach A, the counter returns to 0 and irq pulses for exactly one cycle, giving A ticks per period.
- R5: Start field 00 stops the counter and clears it to 0 in every mode.
- R6: In mode 00 with the external source, the counter counts synchronised ext_in edges: rising edges for start 10 (or 01), falling edges for start 11.
- R7: In mode 01, the counter steps on source ticks only while ext_in is high (start 10) or low (start 11).
- R8: In mode 10 with single-edge set, the start edge (rising for 10/01, falling for 11) clears and starts the counter. The opposite edge copies the count into B, pulses irq and stops the counter until the next start edge.
- R9: In mode 10 with single-edge clear, after the start edge every input edge copies the count into B, pulses irq and restarts the count from 0.
- R10: In mode 00 with a prescaled source and start 10/11, the counter waits for the selected edge before it runs. With trigger-stop set, a further selected edge stops and clears it. With trigger-stop clear, further edges are ignored.
- R11: In mode 11 the output toggles when a step reaches A and toggles again when a step reaches B. At B the counter clears and irq pulses. The output changes in no other mode.
- R12: In mode 11, while stopped, the output follows the initial-level bit. With one-shot set, the generator stops after the first B match until the start field is cleared.
- R13: In modes 00/01 with auto-capture set, B follows every new count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| ext_in | input | 1 | External input (trigger, event, gate, measured pulse) |
| pulse_out | output | 1 | Pulse generator output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench drives the external input as the source clock so that the staging of A can be observed exactly. A lower-byte write must not move the active value, and an upper-byte write must not move it until an input edge arrives. A design that loaded on the write would show the new value early. It checks that a B write outside pulse-generator mode leaves B at its reset value, because a design that lost that gating would expose a stray value. Event counting is checked with a lone rising edge while falling-edge counting is selected, which catches a design that ignores the edge polarity. The trigger-stop test confirms that the counter clears on a second edge. The one-shot test confirms that the output toggles exactly twice, where a continuous generator would keep toggling.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    M_TMR = 2'b00,
    M_WIN = 2'b01,
    M_PW  = 2'b10,
    M_PPG = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_STOP = 2'b00,
    S_CMD  = 2'b01,
    S_RISE = 2'b10,
    S_FALL = 2'b11
  } start_e;

  typedef struct packed {
    logic       oneshot;
    logic       trig_stop;
    logic       single_edge;
    logic       auto_cap;
    logic       init_lvl;
    logic [2:0] src;
    start_e     start;
    mode_e      mode;
  } cfg_t;

  localparam int NUM_TAPS = 3;

endpackage

// File: rtl/mmt_srcsel.sv
module mmt_srcsel #(
  parameter int DIV_SLOW = 11,
  parameter int DIV_MID  = 7,
  parameter int DIV_FAST = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src,
  input  logic       ext_in,
  output logic       tick,
  output logic       rise,
  output logic       fall,
  output logic       lvl
);
  localparam int PW = DIV_SLOW;
  localparam int TAP_W [mmt_pkg::NUM_TAPS] = '{DIV_SLOW, DIV_MID, DIV_FAST};

  logic [PW-1:0] pre;
  logic [mmt_pkg::NUM_TAPS-1:0] tap_hit;
  logic s0, s1, sel_hit;

  // one terminal-count detector per prescaler tap
  for (genvar gi = 0; gi < mmt_pkg::NUM_TAPS; gi++) begin : g_tap
    assign tap_hit[gi] = &pre[TAP_W[gi]-1:0];
  end

  always_comb begin
    case (src)
      3'd0:    sel_hit = tap_hit[0];
      3'd1:    sel_hit = tap_hit[1];
      3'd2:    sel_hit = tap_hit[2];
      default: sel_hit = s1 & ~lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      s0   <= 1'b0;
      s1   <= 1'b0;
      lvl  <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
      tick <= 1'b0;
    end else begin
      pre  <= pre + 1'b1;
      s0   <= ext_in;
      s1   <= s0;
      lvl  <= s1;
      rise <= s1 & ~lvl;
      fall <= ~s1 & lvl;
      tick <= sel_hit;
    end
  end
endmodule

// File: rtl/mmt_dbuf.sv
module mmt_dbuf #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  input  logic          tick,
  input  logic          cap_en,
  input  logic [CW-1:0] cap_val,
  output logic [CW-1:0] val,
  output logic          pend
);
  localparam int HB = CW - 8;

  logic [7:0]    lo_q;
  logic [CW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '1;
      stage_q <= '1;
      val     <= '1;
      pend    <= 1'b0;
    end else begin
      if (cap_en) begin
        val <= cap_val;
      end else if (tick && pend) begin
        val  <= stage_q;
        pend <= 1'b0;
      end
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) begin
        stage_q <= {wdata[HB-1:0], lo_q};
        pend    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic          tick,
  input  logic          rise,
  input  logic          fall,
  input  logic          lvl,
  input  logic [CW-1:0] a_val,
  input  logic [CW-1:0] b_val,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          out,
  output logic          cap_en,
  output logic [CW-1:0] cap_val
);
  logic          run_q, done_q;
  logic [CW-1:0] nxt;
  logic          hit_a, hit_b, st_edge, end_edge, lvl_ok, is_event, tstop, tw_step;

  always_comb begin
    nxt      = count + 1'b1;
    hit_a    = (nxt == a_val);
    hit_b    = (nxt == b_val);
    st_edge  = (cfg.start == S_FALL) ? fall : rise;
    end_edge = (cfg.start == S_FALL) ? rise : fall;
    lvl_ok   = (cfg.start == S_FALL) ? ~lvl : lvl;
    is_event = (cfg.src >= 3'd3);
    tstop    = cfg.trig_stop && (cfg.start != S_CMD) && st_edge;
    tw_step  = 1'b0;
    if (cfg.start != S_STOP) begin
      if (cfg.mode == M_TMR)
        tw_step = is_event ? st_edge : (run_q && tick && !tstop);
      else if (cfg.mode == M_WIN)
        tw_step = tick && lvl_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      irq     <= 1'b0;
      out     <= 1'b0;
      cap_en  <= 1'b0;
      cap_val <= '0;
    end else begin
      irq    <= 1'b0;
      cap_en <= 1'b0;
      if (cfg.start == S_STOP) begin
        count  <= '0;
        run_q  <= 1'b0;
        done_q <= 1'b0;
        if (cfg.mode == M_PPG) out <= cfg.init_lvl;
      end else begin
        if (tw_step) begin
          count   <= hit_a ? '0 : nxt;
          irq     <= hit_a;
          cap_en  <= cfg.auto_cap;
          cap_val <= hit_a ? '0 : nxt;
        end
        case (cfg.mode)
          M_TMR: begin
            if (!is_event) begin
              if (!run_q) begin
                if (cfg.start == S_CMD || st_edge) run_q <= 1'b1;
              end else if (tstop) begin
                run_q <= 1'b0;
                count <= '0;
              end
            end
          end
          M_PW: begin
            if (!run_q) begin
              if (st_edge) begin
                run_q <= 1'b1;
                count <= '0;
              end
            end else if (cfg.single_edge ? end_edge : (rise || fall)) begin
              cap_en  <= 1'b1;
              cap_val <= count;
              irq     <= 1'b1;
              count   <= '0;
              if (cfg.single_edge) run_q <= 1'b0;
            end else if (tick) begin
              count <= nxt;
            end
          end
          M_PPG: begin
            if (!run_q) begin
              if (!done_q) begin
                out <= cfg.init_lvl;
                if (cfg.start == S_CMD || st_edge) run_q <= 1'b1;
              end
            end else if (tick) begin
              if (hit_b) begin
                count <= '0;
                out   <= ~out;
                irq   <= 1'b1;
                if (cfg.oneshot) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
                end
              end else begin
                count <= nxt;
                if (hit_a) out <= ~out;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmt16_timer.sv
module mmt16_timer
  import mmt_pkg::*;
#(
  parameter int CW       = 16,
  parameter int DIV_SLOW = 11,
  parameter int DIV_MID  = 7,
  parameter int DIV_FAST = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ext_in,
  output logic       pulse_out,
  output logic       irq
);
  cfg_t          cfg_q;
  logic          src_tick, rise, fall, lvl;
  logic [CW-1:0] a_val, b_val, count, cap_val;
  logic          a_pend, b_pend, cap_en, b_ok;
  logic [7:0]    rd_mux;

  assign b_ok = (cfg_q.mode == M_PPG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd0) begin
        cfg_q.mode  <= mode_e'(wr_data[1:0]);
        cfg_q.start <= start_e'(wr_data[3:2]);
        cfg_q.src   <= wr_data[6:4];
      end else if (wr_addr == 3'd1) begin
        cfg_q.init_lvl    <= wr_data[0];
        cfg_q.auto_cap    <= wr_data[1];
        cfg_q.single_edge <= wr_data[2];
        cfg_q.trig_stop   <= wr_data[3];
        cfg_q.oneshot     <= wr_data[4];
      end
    end
  end

  mmt_srcsel #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)) u_src (
    .clk(clk), .rst(rst), .src(cfg_q.src), .ext_in(ext_in),
    .tick(src_tick), .rise(rise), .fall(fall), .lvl(lvl)
  );

  mmt_dbuf #(.CW(CW)) u_reg_a (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && wr_addr == 3'd2), .wr_hi(wr_en && wr_addr == 3'd3),
    .wdata(wr_data), .tick(src_tick), .cap_en(1'b0), .cap_val('0),
    .val(a_val), .pend(a_pend)
  );

  mmt_dbuf #(.CW(CW)) u_reg_b (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && b_ok && wr_addr == 3'd4), .wr_hi(wr_en && b_ok && wr_addr == 3'd5),
    .wdata(wr_data), .tick(src_tick), .cap_en(cap_en), .cap_val(cap_val),
    .val(b_val), .pend(b_pend)
  );

  mmt_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .cfg(cfg_q), .tick(src_tick), .rise(rise), .fall(fall),
    .lvl(lvl), .a_val(a_val), .b_val(b_val), .count(count), .irq(irq),
    .out(pulse_out), .cap_en(cap_en), .cap_val(cap_val)
  );

  always_comb begin
    case (rd_addr)
      3'd0:    rd_mux = {1'b0, cfg_q.src, cfg_q.start, cfg_q.mode};
      3'd1:    rd_mux = {3'b000, cfg_q.oneshot, cfg_q.trig_stop, cfg_q.single_edge,
                         cfg_q.auto_cap, cfg_q.init_lvl};
      3'd2:    rd_mux = a_val[7:0];
      3'd3:    rd_mux = 8'(a_val >> 8);
      3'd4:    rd_mux = b_val[7:0];
      3'd5:    rd_mux = 8'(b_val >> 8);
      3'd6:    rd_mux = count[7:0];
      default: rd_mux = 8'(count >> 8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/mmt16_timer_chk.sv
module mmt16_timer_chk
  import mmt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          pulse_out,
  input logic          src_tick,
  input logic          b_pend,
  input logic          cap_en,
  input cfg_t          cfg_q,
  input logic [CW-1:0] a_val,
  input logic [CW-1:0] b_val,
  input logic [CW-1:0] count
);
  // R4
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && cfg_q.mode != M_PW) |=> !irq);

  // R2
  a_load_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !src_tick |=> $stable(a_val));

  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !b_pend) |=> $stable(b_val));

  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.start == S_STOP) |=> (count == '0));

  // R11
  out_ppg_only_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode != M_PPG) |=> $stable(pulse_out));
endmodule

bind mmt16_timer mmt16_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .pulse_out(pulse_out), .src_tick(src_tick),
  .b_pend(b_pend), .cap_en(cap_en), .cfg_q(cfg_q), .a_val(a_val), .b_val(b_val),
  .count(count)
);

// File: tb/mmt16_timer_test.sv
`timescale 1ns/1ps
module mmt16_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       pulse_out, irq;

  int n_cmp = 0, n_bad = 0;
  int irq_cnt = 0, irq_wide = 0, tog = 0;
  logic irq_last = 1'b0, out_last = 1'b0;
  bit finished = 0;

  // {source, A value, expected irq period in clocks}
  localparam logic [34:0] VEC [5] = '{
    {3'd2, 16'd5,  16'd40},
    {3'd2, 16'd1,  16'd8},
    {3'd2, 16'd12, 16'd96},
    {3'd1, 16'd3,  16'd384},
    {3'd0, 16'd1,  16'd2048}
  };

  always #2 clk = ~clk;

  mmt16_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in),
    .pulse_out(pulse_out), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_last) irq_wide++;
    if (pulse_out != out_last) tog++;
    irq_last = irq;
    out_last = pulse_out;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output int d);
    @(negedge clk);
    rd_addr = ad;
    @(negedge clk);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic rd16(input logic [2:0] ad_lo, output int d);
    int lo, hi;
    rd(ad_lo, lo);
    rd(ad_lo + 3'd1, hi);
    d = (hi << 8) | lo;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic ext_pulse();
    ext_in = 1'b1; wait_n(6);
    ext_in = 1'b0; wait_n(6);
  endtask

  task automatic wait_irq_period(output int n);
    int g = 0;
    while (!irq && g < 20000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 20000);
  endtask

  initial begin
    int v, v2, per, i0, t0, hi_w, lo_w;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);

    // R1 reset state
    rd(3'd0, v);  chk("R1 ctrl lo", v, 0);
    rd(3'd1, v);  chk("R1 ctrl hi", v, 0);
    rd16(3'd2, v); chk("R1 A", v, 16'hFFFF);
    rd16(3'd4, v); chk("R1 B", v, 16'hFFFF);
    chk("R1 outputs", {pulse_out, irq}, 0);

    // R2 staging, external source so the load point is controlled
    wr(3'd0, 8'h70);
    wr(3'd2, 8'h34);
    wait_n(20); ext_pulse();
    rd16(3'd2, v); chk("R2 low byte only", v, 16'hFFFF);
    wr(3'd3, 8'h12);
    wait_n(20);
    rd16(3'd2, v); chk("R2 before tick", v, 16'hFFFF);
    ext_pulse();
    rd16(3'd2, v); chk("R2 after tick", v, 16'h1234);

    // R3 B write outside pulse generator mode
    wr(3'd4, 8'h55); wr(3'd5, 8'h66);
    ext_pulse();
    rd16(3'd4, v); chk("R3 B ignored", v, 16'hFFFF);

    // R6 event counting
    wr(3'd0, 8'h78);
    ext_pulse(); ext_pulse(); ext_pulse();
    rd16(3'd6, v); chk("R6 rising events", v, 3);
    wr(3'd0, 8'h7C);
    ext_in = 1'b1; wait_n(10);
    rd16(3'd6, v); chk("R6 rise ignored on falling count", v, 3);
    ext_in = 1'b0; wait_n(10);
    rd16(3'd6, v); chk("R6 falling event", v, 4);

    // R5 stop clears
    wr(3'd0, 8'h70);
    rd16(3'd6, v); chk("R5 stop clears", v, 0);

    // R4 periodic timer table
    wr(3'd1, 8'h00);
    for (int k = 0; k < 5; k++) begin
      logic [2:0]  sel;
      logic [15:0] av, pv;
      int div;
      {sel, av, pv} = VEC[k];
      div = (sel == 3'd0) ? 2048 : (sel == 3'd1) ? 128 : 8;
      wr(3'd0, {1'b0, sel, 4'b0000});
      wr(3'd2, av[7:0]);
      wr(3'd3, av[15:8]);
      wait_n(2 * div + 8);
      wr(3'd0, {1'b0, sel, 4'b0100});
      wait_irq_period(per);
      chk("R4 irq period", per, int'(pv));
    end
    chk("R4 irq width", irq_wide, 0);

    // R10 trigger start and stop
    wr(3'd0, 8'h20);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wait_n(30);
    wr(3'd1, 8'h08);
    wr(3'd0, 8'h28);
    wait_n(50);
    rd16(3'd6, v); chk("R10 waits for edge", v, 0);
    ext_in = 1'b1; wait_n(80); ext_in = 1'b0; wait_n(20);
    rd(3'd6, v); chk_rng("R10 running after edge", v, 5, 20);
    ext_in = 1'b1; wait_n(40);
    rd16(3'd6, v); chk("R10 second edge stops", v, 0);
    ext_in = 1'b0;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h20); wr(3'd0, 8'h28);
    wait_n(10);
    ext_in = 1'b1; wait_n(40); ext_in = 1'b0; wait_n(10);
    ext_in = 1'b1; wait_n(40);
    rd(3'd6, v); chk_rng("R10 start-only keeps running", v, 8, 16);

    // R13 auto-capture
    wr(3'd1, 8'h02);
    wait_n(20);
    rd(3'd4, v);
    wait_n(40);
    rd(3'd4, v2);
    chk_rng("R13 B follows count", (v2 - v) & 255, 3, 10);
    wr(3'd1, 8'h00);

    // R7 window gating
    ext_in = 1'b0;
    wr(3'd0, 8'h20); wr(3'd0, 8'h29);
    wait_n(100);
    rd16(3'd6, v); chk("R7 gate closed", v, 0);
    ext_in = 1'b1; wait_n(160); ext_in = 1'b0; wait_n(20);
    rd16(3'd6, v); chk_rng("R7 counts while high", v, 18, 22);
    wait_n(80);
    rd16(3'd6, v2); chk("R7 holds while low", v2, v);
    wr(3'd0, 8'h2D);
    wait_n(80);
    rd16(3'd6, v2); chk_rng("R7 negative polarity", v2 - v, 8, 12);

    // R8 single-edge width capture
    wr(3'd0, 8'h22);
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h2A);
    wait_n(10);
    i0 = irq_cnt;
    ext_in = 1'b1; wait_n(160); ext_in = 1'b0; wait_n(20);
    rd16(3'd4, v); chk_rng("R8 captured width", v, 19, 21);
    chk("R8 one irq", irq_cnt - i0, 1);

    // R9 double-edge capture
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h22); wr(3'd0, 8'h2A);
    wait_n(10);
    i0 = irq_cnt;
    ext_in = 1'b1; wait_n(80); ext_in = 1'b0; wait_n(40); ext_in = 1'b1; wait_n(20);
    rd16(3'd4, v); chk_rng("R9 last interval", v, 4, 6);
    chk("R9 two irqs", irq_cnt - i0, 2);
    wr(3'd0, 8'h22);
    ext_in = 1'b0; wait_n(10);

    // R12 initial level, R3 B writable, R11 continuous generation
    wr(3'd0, 8'h23);
    wr(3'd1, 8'h01); wait_n(10);
    chk("R12 init level 1", pulse_out, 1);
    wr(3'd1, 8'h00); wait_n(10);
    chk("R12 init level 0", pulse_out, 0);
    wr(3'd4, 8'h06); wr(3'd5, 8'h00);
    wr(3'd2, 8'h02); wr(3'd3, 8'h00);
    wait_n(30);
    rd16(3'd4, v); chk("R3 B written in generator mode", v, 6);
    wr(3'd0, 8'h27);
    t0 = 0;
    while (pulse_out && t0 < 1000) begin @(negedge clk); t0++; end
    while (!pulse_out && t0 < 1000) begin @(negedge clk); t0++; end
    hi_w = 0;
    do begin @(negedge clk); hi_w++; end while (pulse_out && hi_w < 1000);
    lo_w = 0;
    do begin @(negedge clk); lo_w++; end while (!pulse_out && lo_w < 1000);
    chk("R11 high time", hi_w, 32);
    chk("R11 low time", lo_w, 16);

    // R12 one-shot
    wr(3'd0, 8'h23);
    wr(3'd1, 8'h10);
    wait_n(10);
    t0 = tog; i0 = irq_cnt;
    wr(3'd0, 8'h27);
    wait_n(300);
    chk("R12 one-shot toggles", tog - t0, 2);
    chk("R12 one-shot irq", irq_cnt - i0, 1);
    chk("R12 one-shot final level", pulse_out, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule